// File: doc/BRIEF.md
# Sixteen-Pin Polarity-Select GPIO Bank

This block is one bank of general-purpose pins that a processor manages over a plain register bus. The bus has an address, a write enable, write data and combinational read data. Software changes one pin by reading a register, editing the bit and writing the word back. For each pin the bank holds a direction bit, an output value, a synchronized copy of the pad input and an ownership bit. A pin drives its pad only when the processor owns it and it is configured as an output.

Each pin can raise an interrupt on one edge of its input. A single polarity bit picks rising or falling. There is no level mode and no mode that fires on both edges. A detected edge sets a sticky status bit, and it does so even while the pin is masked. A mask register, where a 1 blocks the pin, decides which status bits reach the one aggregated interrupt line. Software clears status by writing ones to the status register.

Top module: `legacy_pin_bank`

## Requirements
- R1: After reset the direction and mask registers read 0xFFFF, and output, edge-select, status and ownership read 0. `irqOut` is 0 and `padOe` is 0.
- R2: Registers are decoded at these byte offsets: input 0x00, output 0x04, direction 0x08, edge-select 0x0C, mask 0x10, status 0x14, ownership 0x18. Read data is zero-extended above bit 15. Any other address reads 0. A write to the input register has no effect.
- R3: The input register returns the pad inputs through a two-flop synchronizer. A pad change set up before clock edge k is readable after edge k+1.
- R4: In the edge-select register, a bit of 1 picks rising-edge detection for that pin and 0 picks falling. Only the picked edge sets the status bit. A pad change set up before edge k sets status at edge k+2.
- R5: Status bits are sticky. Writing status clears each bit written as 1, and a bit written as 0 is unchanged.
- R6: Status sets even when the pin is masked, where a mask bit of 1 blocks the pin. `irqOut` is the OR over all pins of status AND NOT mask.
- R7: `padOe[i]` is 1 only when ownership bit i is 1 and direction bit i is 0, where direction 0 means output. `padOut` equals the output register.
- R8: If an edge and a status clear for the same bit happen in the same cycle, the bit ends set.
- R9: Write-data bits above bit 15 are ignored, and registers read back only their low 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 5 | Byte address of register |
| regWe | input | 1 | Write strobe, one cycle per write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from `regAddr` |
| padIn | input | 16 | Asynchronous pad inputs |
| padOut | output | 16 | Pad output values |
| padOe | output | 16 | Pad output enables |
| irqOut | output | 1 | Aggregated interrupt |

## Verification
The bench steps a pin through both polarities. It checks that the unselected edge leaves status alone, so a design that treated every edge alike would set bits it should not. It samples status one cycle before and exactly at the expected edge, which exposes a synchronizer with a missing or extra stage. It also lands a status clear on the same cycle as a fresh edge: a design where the clear wins would lose that event. A masked pin must still set status while `irqOut` stays low, and a write of zeros to status must clear nothing; a design that confused mask with status gating, or treated the status write as a plain store, would fail these checks.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

  // Byte offsets decoded on the register bus
  localparam int OFS_IN   = 'h00;
  localparam int OFS_OUT  = 'h04;
  localparam int OFS_DIR  = 'h08;
  localparam int OFS_EDGE = 'h0C;
  localparam int OFS_MASK = 'h10;
  localparam int OFS_STAT = 'h14;
  localparam int OFS_OWN  = 'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IN,
    SEL_OUT,
    SEL_DIR,
    SEL_EDGE,
    SEL_MASK,
    SEL_STAT,
    SEL_OWN
  } rdSel_e;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic   wrOut;
    logic   wrDir;
    logic   wrEdge;
    logic   wrMask;
    logic   wrClr;
    logic   wrOwn;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output strobe_t           strb
);

  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(OFS_EDGE);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFS_OWN);

  always_comb begin
    strb        = '0;
    strb.rdSel  = SEL_NONE;
    unique case (regAddr)
      A_IN:   strb.rdSel = SEL_IN;
      A_OUT:  begin strb.rdSel = SEL_OUT;  strb.wrOut  = regWe; end
      A_DIR:  begin strb.rdSel = SEL_DIR;  strb.wrDir  = regWe; end
      A_EDGE: begin strb.rdSel = SEL_EDGE; strb.wrEdge = regWe; end
      A_MASK: begin strb.rdSel = SEL_MASK; strb.wrMask = regWe; end
      A_STAT: begin strb.rdSel = SEL_STAT; strb.wrClr  = regWe; end
      A_OWN:  begin strb.rdSel = SEL_OWN;  strb.wrOwn  = regWe; end
      default: strb.rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/pin_bank_datapath.sv
module pin_bank_datapath
  import pin_bank_pkg::*;
#(
  parameter int PINS        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [PINS-1:0] wdata,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] rdata,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  output logic            irqOut,
  output logic [PINS-1:0] dirQ,
  output logic [PINS-1:0] maskQ,
  output logic [PINS-1:0] statusQ,
  output logic [PINS-1:0] ownQ
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [PINS-1:0] outQ;
  logic [PINS-1:0] edgeQ;
  logic [PINS-1:0] syncQ [SYNC_STAGES];
  logic [PINS-1:0] prevQ;
  logic [PINS-1:0] edgeHit;
  logic [PINS-1:0] clrBits;

  // Input synchronizer plus one sample of history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST];
    end
  end

  // One detector per pin; polarity bit picks which transition counts
  for (genvar g = 0; g < PINS; g++) begin : gEdge
    logic rise;
    logic fall;
    assign rise       = syncQ[LAST][g] & ~prevQ[g];
    assign fall       = ~syncQ[LAST][g] & prevQ[g];
    assign edgeHit[g] = edgeQ[g] ? rise : fall;
  end

  assign clrBits = strb.wrClr ? wdata : '0;

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ  <= '0;
      dirQ  <= '1;
      edgeQ <= '0;
      maskQ <= '1;
      ownQ  <= '0;
    end else begin
      if (strb.wrOut)  outQ  <= wdata;
      if (strb.wrDir)  dirQ  <= wdata;
      if (strb.wrEdge) edgeQ <= wdata;
      if (strb.wrMask) maskQ <= wdata;
      if (strb.wrOwn)  ownQ  <= wdata;
    end
  end

  // Sticky status: a fresh edge overrides a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrBits) | edgeHit;
  end

  assign irqOut = |(statusQ & ~maskQ);
  assign padOut = outQ;
  assign padOe  = ownQ & ~dirQ;

  always_comb begin
    unique case (strb.rdSel)
      SEL_IN:   rdata = syncQ[LAST];
      SEL_OUT:  rdata = outQ;
      SEL_DIR:  rdata = dirQ;
      SEL_EDGE: rdata = edgeQ;
      SEL_MASK: rdata = maskQ;
      SEL_STAT: rdata = statusQ;
      SEL_OWN:  rdata = ownQ;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/legacy_pin_bank.sv
module legacy_pin_bank
  import pin_bank_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic              irqOut
);

  strobe_t         strb;
  logic [PINS-1:0] rdLow;
  logic [PINS-1:0] dirQ;
  logic [PINS-1:0] maskQ;
  logic [PINS-1:0] statusQ;
  logic [PINS-1:0] ownQ;
  logic            unusedWdataHi;

  assign unusedWdataHi = ^regWdata[DATA_W-1:PINS];

  pin_bank_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regAddr (regAddr),
    .regWe   (regWe),
    .strb    (strb)
  );

  pin_bank_datapath #(.PINS(PINS), .SYNC_STAGES(2)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (regWdata[PINS-1:0]),
    .padIn   (padIn),
    .rdata   (rdLow),
    .padOut  (padOut),
    .padOe   (padOe),
    .irqOut  (irqOut),
    .dirQ    (dirQ),
    .maskQ   (maskQ),
    .statusQ (statusQ),
    .ownQ    (ownQ)
  );

  assign regRdata = DATA_W'(rdLow);

endmodule

// File: rtl/pin_bank_checker.sv
module pin_bank_checker
  import pin_bank_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [PINS-1:0]   padOe,
  input logic              irqOut,
  input logic [PINS-1:0]   dirQ,
  input logic [PINS-1:0]   maskQ,
  input logic [PINS-1:0]   statusQ,
  input logic [PINS-1:0]   ownQ
);

  logic statWrite;
  assign statWrite = regWe && (regAddr == ADDR_W'(OFS_STAT));

  assert_oe_owned_R7: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & ~ownQ) == '0);

  assert_oe_output_dir_R7: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & dirQ) == '0);

  assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    !statWrite |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  assert_all_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |-> !irqOut);

  assert_irq_needs_status_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusQ != '0));

endmodule

bind legacy_pin_bank pin_bank_checker #(.PINS(PINS), .ADDR_W(ADDR_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .regAddr (regAddr),
  .regWe   (regWe),
  .padOe   (padOe),
  .irqOut  (irqOut),
  .dirQ    (dirQ),
  .maskQ   (maskQ),
  .statusQ (statusQ),
  .ownQ    (ownQ)
);

// File: tb/sim_legacy_pin_bank.sv
`timescale 1ns/100ps
module sim_legacy_pin_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [15:0] padIn = '0;
  logic [15:0] padOut;
  logic [15:0] padOe;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  legacy_pin_bank u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [4:0]  addr;
    logic        wr;
    logic [31:0] wdata;
    logic [31:0] expRd;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{5'h04, 1'b1, 32'h0000A5C3, 32'h0000A5C3},  // R2 output
    '{5'h04, 1'b1, 32'hFFFF1234, 32'h00001234},  // R9 upper bits dropped
    '{5'h08, 1'b1, 32'h000000F0, 32'h000000F0},  // R2 direction
    '{5'h0C, 1'b1, 32'h00005555, 32'h00005555},  // R2 edge select
    '{5'h10, 1'b1, 32'h00000F0F, 32'h00000F0F},  // R2 mask
    '{5'h18, 1'b1, 32'h0000FFFF, 32'h0000FFFF},  // R2 ownership
    '{5'h00, 1'b1, 32'h0000FFFF, 32'h00000000},  // R2 input write ignored
    '{5'h1C, 1'b1, 32'h0000FFFF, 32'h00000000},  // R2 unmapped
    '{5'h14, 1'b1, 32'h0000FFFF, 32'h00000000},  // R5 clear of clear status
    '{5'h02, 1'b0, 32'h00000000, 32'h00000000}   // R2 unaligned reads zero
  };

  task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readChk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    expect32(tag, regRdata, exp);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    padIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    readChk("R1 dir", 5'h08, 32'hFFFF);
    readChk("R1 mask", 5'h10, 32'hFFFF);
    readChk("R1 out", 5'h04, 32'h0);
    readChk("R1 edge", 5'h0C, 32'h0);
    readChk("R1 status", 5'h14, 32'h0);
    readChk("R1 own", 5'h18, 32'h0);
    expect32("R1 irqOut", {31'b0, irqOut}, 32'h0);
    expect32("R1 padOe", {16'b0, padOe}, 32'h0);

    // Table walk: R2 R9 register decode
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].wr) regWrite(VECS[i].addr, VECS[i].wdata);
      readChk($sformatf("R2 R9 vector %0d", i), VECS[i].addr, VECS[i].expRd);
    end

    // R7 pad drive: own=FFFF dir=00F0 out=1234
    expect32("R7 padOe", {16'b0, padOe}, 32'hFF0F);
    expect32("R7 padOut", {16'b0, padOut}, 32'h1234);
    regWrite(5'h18, 32'h00FF);
    expect32("R7 padOe partial own", {16'b0, padOe}, 32'h000F);

    // Edge tests: pin0 rising, pin1 falling, only pin0 unmasked
    doReset();
    regWrite(5'h0C, 32'h0001);
    regWrite(5'h10, 32'hFFFE);
    regWrite(5'h14, 32'hFFFF);
    padIn = 16'h0003;
    @(negedge clk);
    readChk("R3 input not yet", 5'h00, 32'h0);
    @(negedge clk);
    readChk("R3 input synced", 5'h00, 32'h3);
    readChk("R4 status early", 5'h14, 32'h0);
    @(negedge clk);
    readChk("R4 rising pin0 only", 5'h14, 32'h1);
    expect32("R6 irq unmasked", {31'b0, irqOut}, 32'h1);
    regWrite(5'h14, 32'h0001);
    readChk("R5 cleared", 5'h14, 32'h0);
    expect32("R6 irq after clear", {31'b0, irqOut}, 32'h0);

    padIn = 16'h0000;
    repeat (3) @(negedge clk);
    readChk("R4 falling pin1 only", 5'h14, 32'h2);
    expect32("R6 masked pin no irq", {31'b0, irqOut}, 32'h0);
    regWrite(5'h14, 32'h0001);
    readChk("R5 zero bit kept", 5'h14, 32'h2);
    regWrite(5'h14, 32'h0002);
    readChk("R5 one bit cleared", 5'h14, 32'h0);

    // R8: edge detected on the same edge a clear commits
    padIn = 16'h0001;
    @(negedge clk);
    @(negedge clk);
    regAddr = 5'h14; regWdata = 32'h0001; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    readChk("R8 edge beats clear", 5'h14, 32'h1);
    expect32("R8 irq set", {31'b0, irqOut}, 32'h1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule